// File: doc/BRIEF.md
# EDO DRAM Strobe-Protocol Cycle Decoder

This block is the device side of a multiplexed-address DRAM with extended-data-out page access. It is meant to sit behind a memory controller as a synthesizable protocol checker or as a small memory stand-in. The four active-low strobes (row strobe, column strobe, write enable, output enable) are sampled as synchronous inputs on a fast clock. The block finds their falling and rising edges and works out the cycle type from the order in which those edges arrive. It then latches row and column addresses, reads or writes a small internal nibble array, and decides whether the 4-bit data bus is driven.

The cycle types covered are: read, early write, late write, read-modify-write, page-mode accesses within one open row, row-strobe-only refresh, column-before-row refresh with an internal 11-bit row counter, and hidden refresh that keeps earlier read data on the bus. The data bus is split into a data-in port, a data-out port and a drive-enable; an enable of 0 stands for high impedance. For the bench there are a cycle-type code, a page flag, the row most recently refreshed, and a one-cycle flag for row and column strobes falling in the same sample.

Top module: `edo_strobe_decoder`

## Requirements
- R1: A falling row strobe latches the row from `addr`, and a falling column strobe latches the column from `addr`. The array is indexed by the low ROW_BITS of the row and the low COL_BITS of the column. A value written at (row, column) is returned by a later read of that same location.
- R2: During and straight after reset: `dq_oe`=0, `cyc_type`=0, `cyc_page`=0, `viol`=0, `rfsh_row`=0, and the refresh counter is 0.
- R3: When the column strobe falls in an open, non-refresh row cycle with write enable high, `cyc_type` becomes 1 (read). If output enable is low, `dq_out` carries the cell and `dq_oe`=1. If output enable is high, the bus stays undriven until output enable falls, and then the cell is driven.
- R4: When write enable is already low as the column strobe falls, `dq_in` is written, `cyc_type` becomes 2 (early write), and `dq_oe` stays 0 for the whole access.
- R5: When write enable falls after the column strobe while the column strobe is still low, `dq_in` is written to the latched location and the bus is released. `cyc_type` becomes 3 (late write) if no read data was on the bus, and 4 (read-modify-write) if read data was being driven.
- R6: `dq_oe` goes to 0 on the clock after a sample that has output enable high, or both row and column strobes high, or a falling write enable.
- R7: Within one open row, each further column-strobe fall latches a new column and sets `cyc_page`=1; the first access in a row gives `cyc_page`=0. Read data stays driven after the column strobe rises.
- R8: A falling row strobe while the column strobe was high gives `cyc_type` 5 (row-only refresh), and `rfsh_row` takes the full `addr` value.
- R9: A falling row strobe while the column strobe was already low is a counter refresh: `cyc_type` becomes 6, `rfsh_row` takes the counter value, and `addr` is ignored. The counter then advances by one, modulo 2048, and the bus is not driven.
- R10: A counter refresh that begins while read data is driven (column strobe held low after a read, row strobe cycled) gives `cyc_type` 7 (hidden refresh). The read data stays on `dq_out` with `dq_oe`=1.
- R11: Row and column strobes falling in the same sample raise `viol` for one cycle. That cycle is a row-only refresh (`cyc_type` 5), and the column fall is ignored, so no access and no bus drive follow.
- R12: Every output changes on the first rising clock edge that samples the strobe change, never before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (11) | Multiplexed row/column address |
| dq_in | input | 4 | Write data from the bus |
| dq_out | output | 4 | Read data onto the bus |
| dq_oe | output | 1 | Bus drive enable; 0 means high impedance |
| cyc_type | output | 4 | Last cycle class: 0 none, 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 row-only refresh, 6 counter refresh, 7 hidden refresh |
| cyc_page | output | 1 | Last access was not the first in its row |
| viol | output | 1 | Row and column strobes fell in one sample |
| rfsh_row | output | ADDR_W (11) | Row refreshed by the latest row-strobe fall |

## Verification
A stale row or column latch shows at the ports as wrong read data on the very next read of an affected location. The bench reaches every cell, because it writes all of them in page mode and reads them back. A refresh counter that is stuck, skips, or moves on row-only cycles shows on `rfsh_row` one clock after the next counter refresh; the sweep runs past the 2048 wrap. A wrong bus-drive state (for example a lost "read data present" bit) shows one clock after the strobe edge, either as a wrong `dq_oe` or as a late write that is misreported as read-modify-write, or the reverse.

// File: rtl/edo_pkg.sv
package edo_pkg;

    localparam int DQ_W = 4;

    // Cycle class codes seen on cyc_type
    typedef enum logic [3:0] {
        CY_NONE   = 4'd0,
        CY_READ   = 4'd1,
        CY_EWR    = 4'd2,
        CY_LWR    = 4'd3,
        CY_RMW    = 4'd4,
        CY_RONLY  = 4'd5,
        CY_CBR    = 4'd6,
        CY_HIDDEN = 4'd7
    } cyc_e;

    // Strobe set, each bit 1 = asserted (pin low)
    typedef struct packed {
        logic ras;
        logic cas;
        logic we;
        logic oe;
    } strobe_t;

    function automatic strobe_t to_active(input logic ras_n, input logic cas_n,
                                          input logic we_n, input logic oe_n);
        strobe_t s;
        s.ras = ~ras_n;
        s.cas = ~cas_n;
        s.we  = ~we_n;
        s.oe  = ~oe_n;
        return s;
    endfunction

endpackage

// File: rtl/edo_edge_detect.sv
module edo_edge_detect
    import edo_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t now_s,
    output strobe_t prev_s,
    output strobe_t on_s,
    output strobe_t off_s
);
    always_ff @(posedge clk) begin
        if (rst) prev_s <= '0;
        else     prev_s <= now_s;
    end

    assign on_s  = now_s & ~prev_s;
    assign off_s = ~now_s & prev_s;
endmodule

// File: rtl/edo_refresh_ctr.sv
module edo_refresh_ctr #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (step) count <= count + 1'b1;
    end
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
    parameter int IDX_W = 6,
    parameter int DW    = 4
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_idx] <= wr_data;
    end

    assign rd_data = cells[rd_idx];
endmodule

// File: rtl/edo_strobe_decoder.sv
module edo_strobe_decoder
    import edo_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic [3:0]        cyc_type,
    output logic              cyc_page,
    output logic              viol,
    output logic [ADDR_W-1:0] rfsh_row
);
    localparam int IDX_W = ROW_BITS + COL_BITS;

    strobe_t act, prev, fall, rise;
    assign act = to_active(ras_n, cas_n, we_n, oe_n);

    edo_edge_detect u_edge (
        .clk(clk), .rst(rst), .now_s(act),
        .prev_s(prev), .on_s(fall), .off_s(rise)
    );

    logic unused_edges;
    assign unused_edges = ^{prev.we, prev.oe, rise.we, rise.oe};

    // Decoded events
    logic cbr_start, coincide, acc_start, late_wr, late_rd;
    logic cbr_cyc, cas_on, wrote, had_acc;
    logic [ROW_BITS-1:0] row_q;
    logic [COL_BITS-1:0] col_q;
    logic [ADDR_W-1:0]   ctr;
    cyc_e cyc_q;

    always_comb begin
        cbr_start = fall.ras & prev.cas & act.cas;
        coincide  = fall.ras & fall.cas;
        acc_start = fall.cas & prev.ras & act.ras & ~cbr_cyc;
        late_wr   = cas_on & ~fall.cas & fall.we & ~wrote & act.ras & act.cas;
        late_rd   = cas_on & ~fall.cas & fall.oe & ~wrote & act.cas;
    end

    edo_refresh_ctr #(.W(ADDR_W)) u_ctr (
        .clk(clk), .rst(rst), .step(cbr_start), .count(ctr)
    );

    // Array index: new column on an access start, latched column afterwards
    logic [IDX_W-1:0] cell_idx;
    logic [DQ_W-1:0]  rd_data;
    logic             wr_en;
    assign cell_idx = acc_start ? {row_q, addr[COL_BITS-1:0]} : {row_q, col_q};
    assign wr_en    = (acc_start & act.we) | late_wr;

    edo_cell_array #(.IDX_W(IDX_W), .DW(DQ_W)) u_arr (
        .clk(clk), .wr_en(wr_en), .wr_idx(cell_idx), .wr_data(dq_in),
        .rd_idx(cell_idx), .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cbr_cyc  <= 1'b0;
            cas_on   <= 1'b0;
            wrote    <= 1'b0;
            had_acc  <= 1'b0;
            row_q    <= '0;
            col_q    <= '0;
            cyc_q    <= CY_NONE;
            cyc_page <= 1'b0;
            viol     <= 1'b0;
            rfsh_row <= '0;
            dq_oe    <= 1'b0;
            dq_out   <= '0;
        end else begin
            viol <= coincide;
            // Row strobe edges open and close a row cycle
            if (fall.ras) begin
                had_acc <= 1'b0;
                cas_on  <= 1'b0;
                if (cbr_start) begin
                    cbr_cyc  <= 1'b1;
                    rfsh_row <= ctr;
                    cyc_q    <= dq_oe ? CY_HIDDEN : CY_CBR;
                end else begin
                    cbr_cyc  <= 1'b0;
                    row_q    <= addr[ROW_BITS-1:0];
                    rfsh_row <= addr;
                    cyc_q    <= CY_RONLY;
                    cyc_page <= 1'b0;
                end
            end else if (rise.ras) begin
                cbr_cyc <= 1'b0;
                cas_on  <= 1'b0;
            end
            // Column accesses and late commands
            if (acc_start) begin
                col_q    <= addr[COL_BITS-1:0];
                cas_on   <= 1'b1;
                cyc_page <= had_acc;
                had_acc  <= 1'b1;
                if (act.we) begin
                    wrote <= 1'b1;
                    cyc_q <= CY_EWR;
                    dq_oe <= 1'b0;
                end else begin
                    wrote <= 1'b0;
                    cyc_q <= CY_READ;
                    dq_oe <= act.oe;
                    if (act.oe) dq_out <= rd_data;
                end
            end else if (late_wr) begin
                wrote <= 1'b1;
                cyc_q <= dq_oe ? CY_RMW : CY_LWR;
                dq_oe <= 1'b0;
            end else if (late_rd) begin
                dq_oe  <= 1'b1;
                dq_out <= rd_data;
            end else if (rise.cas) begin
                cas_on <= 1'b0;
            end
            // Bus release rules take precedence
            if (!act.oe || fall.we || (!act.ras && !act.cas)) dq_oe <= 1'b0;
        end
    end

    assign cyc_type = cyc_q;
endmodule

// File: rtl/edo_checker.sv
module edo_checker #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              dq_oe,
    input logic [3:0]        cyc_type,
    input logic              viol,
    input logic [ADDR_W-1:0] rfsh_row
);
    logic ras_was_hi, cas_was_lo, cbr_edge;
    logic [ADDR_W-1:0] exp_ctr;

    assign cbr_edge = ras_was_hi && !ras_n && cas_was_lo && !cas_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_was_hi <= 1'b1;
            cas_was_lo <= 1'b0;
            exp_ctr    <= '0;
        end else begin
            ras_was_hi <= ras_n;
            cas_was_lo <= !cas_n;
            if (cbr_edge) exp_ctr <= exp_ctr + 1'b1;
        end
    end

    a_r6_idle_hiz: assert property (@(posedge clk) disable iff (rst)
        (ras_n && cas_n) |=> !dq_oe);

    a_r6_oe_gate: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> $past(!oe_n));

    a_r5_we_release: assert property (@(posedge clk) disable iff (rst)
        (!we_n && $past(we_n)) |=> !dq_oe);

    a_r4_early_quiet: assert property (@(posedge clk) disable iff (rst)
        (cyc_type == 4'd2 && !ras_n && !cas_n) |-> !dq_oe);

    a_r9_cbr_quiet: assert property (@(posedge clk) disable iff (rst)
        (cyc_type == 4'd6) |-> !dq_oe);

    a_r9_ctr_step: assert property (@(posedge clk) disable iff (rst)
        cbr_edge |=> (rfsh_row == $past(exp_ctr)));

    a_r11_viol_ronly: assert property (@(posedge clk) disable iff (rst)
        viol |-> (cyc_type == 4'd5));
endmodule

bind edo_strobe_decoder edo_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .dq_oe(dq_oe), .cyc_type(cyc_type), .viol(viol),
    .rfsh_row(rfsh_row)
);

// File: tb/sim_edo_strobe_decoder.sv
module sim_edo_strobe_decoder;
    localparam int ADDR_W = 11;
    localparam int NR = 8;
    localparam int NC = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [3:0] dq_in = '0;
    logic [3:0] dq_out;
    logic       dq_oe;
    logic [3:0] cyc_type;
    logic       cyc_page;
    logic       viol;
    logic [ADDR_W-1:0] rfsh_row;

    int n_chk = 0;
    int n_fail = 0;
    logic [3:0] em [NR*NC];

    edo_strobe_decoder u0 (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .cyc_type(cyc_type), .cyc_page(cyc_page),
        .viol(viol), .rfsh_row(rfsh_row)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [3:0] pat(input int r, input int c);
        return 4'((r * 3 + c * 5 + 1) % 16);
    endfunction

    task automatic read_one(input int r, input int c, input string req);
        addr = ADDR_W'(r); ras_n = 1'b0; step();
        addr = ADDR_W'(c); oe_n = 1'b0; cas_n = 1'b0; step();
        chk({req, " readback oe"}, int'(dq_oe), 1);
        chk({req, " readback data"}, int'(dq_out), int'(em[r*NC+c]));
        cas_n = 1'b1; ras_n = 1'b1; oe_n = 1'b1; step();
    endtask

    initial begin
        int wd = 0;
        while (wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", wd);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R2 reset state
        chk("R2 dq_oe", int'(dq_oe), 0);
        chk("R2 cyc_type", int'(cyc_type), 0);
        chk("R2 cyc_page", int'(cyc_page), 0);
        chk("R2 viol", int'(viol), 0);
        chk("R2 rfsh_row", int'(rfsh_row), 0);

        // R1 R4 R7: early-write every cell in page mode
        for (int r = 0; r < NR; r++) begin
            addr = ADDR_W'(r); ras_n = 1'b0; step();
            chk("R8 row refresh of access row", int'(rfsh_row), r);
            for (int c = 0; c < NC; c++) begin
                addr = ADDR_W'(c); we_n = 1'b0; dq_in = pat(r, c);
                em[r*NC+c] = pat(r, c);
                cas_n = 1'b0; step();
                chk("R4 early write type", int'(cyc_type), 2);
                chk("R4 early write bus off", int'(dq_oe), 0);
                chk("R7 page flag write", int'(cyc_page), (c != 0) ? 1 : 0);
                cas_n = 1'b1; we_n = 1'b1; step();
                chk("R4 bus off after cas", int'(dq_oe), 0);
            end
            ras_n = 1'b1; step();
        end

        // R1 R3 R7 R12: page read every cell, EDO hold after cas rise
        for (int r = 0; r < NR; r++) begin
            addr = ADDR_W'(r); ras_n = 1'b0; step();
            oe_n = 1'b0;
            for (int c = 0; c < NC; c++) begin
                addr = ADDR_W'(c); cas_n = 1'b0;
                #1;
                if (c == 0) chk("R12 no change before edge", int'(dq_oe), 0);
                step();
                chk("R3 read type", int'(cyc_type), 1);
                chk("R3 read drives", int'(dq_oe), 1);
                chk("R1 read data", int'(dq_out), int'(em[r*NC+c]));
                chk("R7 page flag read", int'(cyc_page), (c != 0) ? 1 : 0);
                cas_n = 1'b1; step();
                chk("R7 edo hold oe", int'(dq_oe), 1);
                chk("R7 edo hold data", int'(dq_out), int'(em[r*NC+c]));
            end
            ras_n = 1'b1; step();
            chk("R6 both strobes high", int'(dq_oe), 0);
            oe_n = 1'b1;
        end

        // R3 R6: read with OE falling after CAS
        addr = 11'd2; ras_n = 1'b0; step();
        addr = 11'd3; cas_n = 1'b0; step();
        chk("R3 oe-late type", int'(cyc_type), 1);
        chk("R3 oe-late no drive yet", int'(dq_oe), 0);
        oe_n = 1'b0; step();
        chk("R3 oe-late drive", int'(dq_oe), 1);
        chk("R3 oe-late data", int'(dq_out), int'(em[2*NC+3]));
        oe_n = 1'b1; step();
        chk("R6 oe high releases", int'(dq_oe), 0);
        cas_n = 1'b1; ras_n = 1'b1; step();

        // R5 late write
        addr = 11'd1; ras_n = 1'b0; step();
        addr = 11'd4; cas_n = 1'b0; step();
        we_n = 1'b0; dq_in = 4'hA; step();
        chk("R5 late write type", int'(cyc_type), 3);
        chk("R5 late write bus off", int'(dq_oe), 0);
        em[1*NC+4] = 4'hA;
        we_n = 1'b1; cas_n = 1'b1; ras_n = 1'b1; step();
        read_one(1, 4, "R5 late write");

        // R5 read-modify-write
        addr = 11'd5; ras_n = 1'b0; step();
        addr = 11'd6; oe_n = 1'b0; cas_n = 1'b0; step();
        chk("R5 rmw read data", int'(dq_out), int'(em[5*NC+6]));
        we_n = 1'b0; dq_in = 4'h5; step();
        chk("R5 rmw type", int'(cyc_type), 4);
        chk("R6 we fall releases", int'(dq_oe), 0);
        em[5*NC+6] = 4'h5;
        we_n = 1'b1; oe_n = 1'b1; cas_n = 1'b1; ras_n = 1'b1; step();
        read_one(5, 6, "R5 rmw");

        // R8 row-only refresh
        addr = 11'h5A3; ras_n = 1'b0; step();
        chk("R8 type", int'(cyc_type), 5);
        chk("R8 row", int'(rfsh_row), 'h5A3);
        chk("R8 bus off", int'(dq_oe), 0);
        ras_n = 1'b1; step();

        // R9 counter refresh through wrap
        addr = 11'h7FF; cas_n = 1'b0; step();
        for (int k = 0; k < 2050; k++) begin
            ras_n = 1'b0; step();
            chk("R9 counter row", int'(rfsh_row), k % 2048);
            chk("R9 type", int'(cyc_type), 6);
            chk("R9 bus off", int'(dq_oe), 0);
            ras_n = 1'b1; step();
        end
        cas_n = 1'b1; step();

        // R10 hidden refresh
        addr = 11'd3; ras_n = 1'b0; step();
        addr = 11'd2; oe_n = 1'b0; cas_n = 1'b0; step();
        chk("R10 read before hidden", int'(dq_out), int'(em[3*NC+2]));
        ras_n = 1'b1; step();
        chk("R10 held across ras high", int'(dq_oe), 1);
        ras_n = 1'b0; step();
        chk("R10 hidden type", int'(cyc_type), 7);
        chk("R10 hidden keeps drive", int'(dq_oe), 1);
        chk("R10 hidden keeps data", int'(dq_out), int'(em[3*NC+2]));
        chk("R10 hidden counter row", int'(rfsh_row), 2);
        ras_n = 1'b1; cas_n = 1'b1; oe_n = 1'b1; step();
        chk("R6 release after hidden", int'(dq_oe), 0);

        // R11 coincident strobe fall
        addr = 11'd4; oe_n = 1'b0; ras_n = 1'b0; cas_n = 1'b0; step();
        chk("R11 viol", int'(viol), 1);
        chk("R11 type", int'(cyc_type), 5);
        chk("R11 row", int'(rfsh_row), 4);
        chk("R11 no access", int'(dq_oe), 0);
        step();
        chk("R11 viol one cycle", int'(viol), 0);
        chk("R11 still no drive", int'(dq_oe), 0);
        ras_n = 1'b1; cas_n = 1'b1; oe_n = 1'b1; step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule